// File: doc/BRIEF.md
# Descriptor Ring Memory Copy Engine

This block moves one buffer per ring slot from a source area of memory to a destination area. A ring controller tells it that a slot is pending and which slot that is. The engine then reads the source descriptor and the destination descriptor that sit at that slot index in two separate rings. Each descriptor is 16 bytes long: its first word holds the buffer address and its second word holds control. The engine copies the requested bytes as 32-bit words in bursts, writes a done flag back into the destination descriptor, and pulses an advance strobe so the ring controller can step its index.

All memory traffic goes through one word-wide request/ready port, with one access in flight at a time. Read data is taken in the cycle in which the access is accepted. The burst size and the done write-back enable are static configuration inputs, and they may change only while the engine is idle. The bit positions of the done flag and of the last-segment flag are parameters, so that either descriptor layout can be served.

Top module: `dce_copy_engine`

## Requirements
- R1: After reset, `busy_o`, `advance_o`, `seg_last_o` and `mem_req_o` are all low.
- R2: When `pending_i` is seen while the engine is idle, it reads four words in this order: source descriptor word 0 and word 1, then destination descriptor word 0 and word 1. The source descriptor is at `src_ring_i + 16*slot` and the destination descriptor at `dst_ring_i + 16*slot`; word 1 is at offset 4.
- R3: The byte length is bits 29:16 of source descriptor word 1. The engine copies ceil(length/4) words, in ascending address order, from the source buffer address to the destination buffer address, on word-aligned addresses.
- R4: A length above 0x3F80 bytes is treated as 0x3F80 bytes (4064 words).
- R5: Data moves in bursts: a run of reads into a staging buffer, then writes of the same words. The burst size is set by `burst_sel_i`: 0 gives 1 word, 1 gives 4 words, and 2 or 3 give 16 words (64 bytes). The final burst is shortened to the words that remain.
- R6: With `done_wb_en_i` high, after the last data write the engine writes to destination word 1 the value it fetched there, with bit 31 set, so the length field is kept. With `done_wb_en_i` low, no write-back takes place.
- R7: A length of zero makes no data reads and no data writes. The engine goes straight from the fetch to the write-back, or to the advance if write-back is disabled.
- R8: `advance_o` is a single-cycle pulse in the cycle after the final accepted access of a slot. During that pulse `seg_last_o` equals bit 30 of source descriptor word 1.
- R9: `busy_o` is high from the first fetch cycle through the cycle in which the final access is accepted, and it is low in the advance cycle and in the cycle after it. No new fetch begins in the advance cycle.
- R10: While `mem_req_o` is high and `mem_ready_i` is low, the request, write enable, address and write data are held unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pending_i | input | 1 | The ring controller has a slot ready for copying |
| slot_i | input | IDX_W | Index of the pending slot |
| src_ring_i | input | AW | Byte base address of the source descriptor ring |
| dst_ring_i | input | AW | Byte base address of the destination descriptor ring |
| burst_sel_i | input | 2 | Burst size select (0: 1 word, 1: 4 words, 2/3: 16 words) |
| done_wb_en_i | input | 1 | Enables the done flag write-back |
| advance_o | output | 1 | One-cycle strobe: the slot is finished, step the index |
| seg_last_o | output | 1 | Last-segment flag of the finished slot, valid with advance_o |
| busy_o | output | 1 | The engine is working on a slot |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ready_i | input | 1 | The memory accepts the access this cycle |
| mem_rdata_i | input | 32 | Read data, valid in the accept cycle of a read |

## Verification
Each access is accepted on the rising edge where request and ready are both high. The next access can appear in the following cycle, and `advance_o` rises exactly one cycle after the final accepted access of a slot. The bench drives ready and read data on falling edges. On the same falling edges it compares every accepted access against the next entry of an expected queue, which holds fetch reads, burst reads and writes, and the done write, so the order and the burst grouping are checked as well as the values. At each advance it checks that the last accepted access came on the falling edge just before, that the access count for the slot is right, and that `seg_last_o` is right and `busy_o` is low.

// File: rtl/dce_pkg.sv
package dce_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } dce_state_e;

  localparam int unsigned DESC_SHIFT = 4;  // 16-byte descriptors
endpackage

// File: rtl/dce_beat_plan.sv
module dce_beat_plan #(
  parameter int unsigned WCNT_W    = 12,
  parameter int unsigned BCNT_W    = 5,
  parameter int unsigned MAX_BURST = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WCNT_W-1:0] rem_i,
  input  logic [1:0]        sel_i,
  output logic [BCNT_W-1:0] blen_o
);
  localparam int unsigned MID_BURST = (MAX_BURST < 4) ? MAX_BURST : 4;

  logic [WCNT_W-1:0] cap;

  always_comb begin
    unique case (sel_i)
      2'd0:    cap = WCNT_W'(1);
      2'd1:    cap = WCNT_W'(MID_BURST);
      default: cap = WCNT_W'(MAX_BURST);
    endcase
    blen_o = (rem_i < cap) ? BCNT_W'(rem_i) : BCNT_W'(cap);
  end

  // final burst shortened, never beyond the remaining words
  assert_burst_fit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rem_i != '0) |-> (blen_o != '0 && WCNT_W'(blen_o) <= rem_i && blen_o <= MAX_BURST));
endmodule

// File: rtl/dce_burst_buf.sv
module dce_burst_buf #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];

  // staged word is returned unchanged for the write half of the burst (R5)
  assert_stage_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i ##1 (!wr_en_i && rd_idx_i == $past(wr_idx_i))) |-> rd_data_o == $past(wr_data_i));
endmodule

// File: rtl/dce_copy_engine.sv
module dce_copy_engine
  import dce_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned IDX_W     = 6,
  parameter int unsigned DONE_BIT  = 31,
  parameter int unsigned LAST_BIT  = 30,
  parameter int unsigned MAX_BURST = 16,
  parameter int unsigned MAX_LEN   = 'h3F80
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pending_i,
  input  logic [IDX_W-1:0] slot_i,
  input  logic [AW-1:0]    src_ring_i,
  input  logic [AW-1:0]    dst_ring_i,
  input  logic [1:0]       burst_sel_i,
  input  logic             done_wb_en_i,
  output logic             advance_o,
  output logic             seg_last_o,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic             mem_ready_i,
  input  logic [31:0]      mem_rdata_i
);
  localparam int unsigned LEN_W  = 14;
  localparam int unsigned WCNT_W = $clog2(MAX_LEN / 4 + 1);
  localparam int unsigned BCNT_W = $clog2(MAX_BURST + 1);
  localparam int unsigned BIDX_W = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1;

  dce_state_e        state_q;
  logic [1:0]        fcnt_q;
  logic [IDX_W-1:0]  slot_q;
  logic [AW-1:0]     src_ptr_q, dst_ptr_q;
  logic [31:0]       dctl_q;
  logic              last_q, seg_q, adv_q;
  logic [WCNT_W-1:0] rem_q;
  logic [BCNT_W-1:0] beat_q, blen;
  logic [31:0]       stage_rd;

  logic [AW-1:0]     src_desc, dst_desc;
  logic              acc, burst_end;
  logic [LEN_W-1:0]  len_raw, len_eff;
  logic [LEN_W:0]    len_pad;
  logic [WCNT_W-1:0] words;

  assign src_desc  = src_ring_i + (AW'(slot_q) << DESC_SHIFT);
  assign dst_desc  = dst_ring_i + (AW'(slot_q) << DESC_SHIFT);
  assign acc       = mem_req_o & mem_ready_i;
  assign burst_end = (beat_q == blen - BCNT_W'(1));

  assign len_raw = mem_rdata_i[29:16];
  assign len_eff = (len_raw > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : len_raw;
  assign len_pad = {1'b0, len_eff} + (LEN_W + 1)'(3);
  assign words   = WCNT_W'(len_pad >> 2);

  dce_beat_plan #(.WCNT_W(WCNT_W), .BCNT_W(BCNT_W), .MAX_BURST(MAX_BURST)) i_plan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rem_i  (rem_q),
    .sel_i  (burst_sel_i),
    .blen_o (blen)
  );

  dce_burst_buf #(.DEPTH(MAX_BURST), .DW(32)) i_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (state_q == ST_READ && acc),
    .wr_idx_i  (beat_q[BIDX_W-1:0]),
    .wr_data_i (mem_rdata_i),
    .rd_idx_i  (beat_q[BIDX_W-1:0]),
    .rd_data_o (stage_rd)
  );

  always_comb begin
    mem_req_o  = (state_q != ST_IDLE);
    mem_we_o   = (state_q == ST_WRITE) || (state_q == ST_DONE);
    mem_wdata_o = (state_q == ST_DONE) ? (dctl_q | (32'd1 << DONE_BIT)) : stage_rd;
    unique case (state_q)
      ST_FETCH: mem_addr_o = (fcnt_q[1] ? dst_desc : src_desc) + (fcnt_q[0] ? AW'(4) : AW'(0));
      ST_READ:  mem_addr_o = src_ptr_q;
      ST_WRITE: mem_addr_o = dst_ptr_q;
      ST_DONE:  mem_addr_o = dst_desc + AW'(4);
      default:  mem_addr_o = '0;
    endcase
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign advance_o  = adv_q;
  assign seg_last_o = adv_q & seg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      fcnt_q    <= '0;
      slot_q    <= '0;
      src_ptr_q <= '0;
      dst_ptr_q <= '0;
      dctl_q    <= '0;
      last_q    <= 1'b0;
      seg_q     <= 1'b0;
      adv_q     <= 1'b0;
      rem_q     <= '0;
      beat_q    <= '0;
    end else begin
      adv_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (pending_i && !adv_q) begin  // no restart in the advance cycle
          slot_q  <= slot_i;
          fcnt_q  <= '0;
          state_q <= ST_FETCH;
        end
        ST_FETCH: if (acc) begin
          fcnt_q <= fcnt_q + 2'd1;
          unique case (fcnt_q)
            2'd0: src_ptr_q <= mem_rdata_i;
            2'd1: begin
              rem_q  <= words;
              last_q <= mem_rdata_i[LAST_BIT];
            end
            2'd2: dst_ptr_q <= mem_rdata_i;
            default: begin
              dctl_q <= mem_rdata_i;
              beat_q <= '0;
              if (rem_q != '0) state_q <= ST_READ;
              else if (done_wb_en_i) state_q <= ST_DONE;
              else begin
                state_q <= ST_IDLE;
                adv_q   <= 1'b1;
                seg_q   <= last_q;
              end
            end
          endcase
        end
        ST_READ: if (acc) begin
          src_ptr_q <= src_ptr_q + AW'(4);
          if (burst_end) begin
            beat_q  <= '0;
            state_q <= ST_WRITE;
          end else beat_q <= beat_q + BCNT_W'(1);
        end
        ST_WRITE: if (acc) begin
          dst_ptr_q <= dst_ptr_q + AW'(4);
          if (burst_end) begin
            beat_q <= '0;
            rem_q  <= rem_q - WCNT_W'(blen);
            if (rem_q != WCNT_W'(blen)) state_q <= ST_READ;
            else if (done_wb_en_i) state_q <= ST_DONE;
            else begin
              state_q <= ST_IDLE;
              adv_q   <= 1'b1;
              seg_q   <= last_q;
            end
          end else beat_q <= beat_q + BCNT_W'(1);
        end
        ST_DONE: if (acc) begin
          state_q <= ST_IDLE;
          adv_q   <= 1'b1;
          seg_q   <= last_q;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_adv_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_o |=> !advance_o);

  assert_busy_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> advance_o);

  assert_no_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_o |=> !busy_o);

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

  assert_data_align_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_addr_o[1:0] == 2'b00));
endmodule

// File: tb/test_dce_copy_engine.sv
`timescale 1ns/1ps
module test_dce_copy_engine;
  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } item_t;

  localparam int SRC_RING = 'h1000;
  localparam int DST_RING = 'h2000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        pending;
  logic [2:0]  slot;
  logic [1:0]  bsel = 2'd2;
  logic        wb_en = 1'b1;
  logic        adv, seg_last, busy, req, we, ready = 1'b1;
  logic [31:0] addr, wdata, rdata = '0;

  int total = 0, bad = 0, cyc = 0, prod = 0, cons = 0, k = 0;
  int acc_cnt = 0, last_acc_cyc = -10;
  bit stall_en = 1'b0, stall_prev = 1'b0, done = 1'b0;
  logic [31:0] stall_addr;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] mem [int];
  item_t exp_q[$];
  int    cnt_q[$];
  bit    seg_q[$];

  always #2.5 clk = ~clk;

  dce_copy_engine #(.IDX_W(3)) i_dce_copy_engine (
    .clk_i(clk), .rst_ni(rst_n), .pending_i(pending), .slot_i(slot),
    .src_ring_i(SRC_RING), .dst_ring_i(DST_RING), .burst_sel_i(bsel),
    .done_wb_en_i(wb_en), .advance_o(adv), .seg_last_o(seg_last), .busy_o(busy),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_ready_i(ready), .mem_rdata_i(rdata)
  );

  assign pending = (prod != cons);
  assign slot    = 3'(cons);

  always @(posedge clk) if (rst_n && adv) cons <= cons + 1;

  function automatic logic [31:0] rd_word(input int a);
    if (mem.exists(a)) return mem[a];
    return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // monitor: ready, scoreboard compare, model memory, read data
  always @(negedge clk) begin
    cyc++;
    lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ready = !stall_en || (lfsr[1:0] != 2'b00);
    if (rst_n) begin
      if (stall_prev && req) check(addr == stall_addr, "R10 held address", addr, stall_addr);
      stall_prev = req && !ready;
      stall_addr = addr;
      if (adv) begin
        int n;
        bit s;
        n = (cnt_q.size() != 0) ? cnt_q.pop_front() : -1;
        s = (seg_q.size() != 0) ? seg_q.pop_front() : 1'b0;
        check(acc_cnt == n, "R8 access count", acc_cnt, n);
        check(last_acc_cyc == cyc - 1, "R8 advance timing", last_acc_cyc, cyc - 1);
        check(seg_last == s, "R8 segment flag", seg_last, s);
        check(busy == 1'b0, "R9 busy in advance", busy, 0);
        acc_cnt = 0;
      end
      if (req && ready) begin
        item_t e;
        acc_cnt++;
        last_acc_cyc = cyc;
        if (exp_q.size() == 0) check(1'b0, "R3 unexpected access", addr, 0);
        else begin
          e = exp_q.pop_front();
          check(busy && we == e.we && addr == e.addr && (!e.we || wdata == e.data), e.tag,
                e.we ? wdata : addr, e.we ? e.data : e.addr);
        end
        if (we) mem[int'(addr)] = wdata;
      end
    end
    rdata = rd_word(int'(addr));
  end

  task automatic push_desc(input int len, input bit last);
    int sd, dd, srca, dsta, le, words, rem, off, b, bw;
    logic [31:0] sw1, dw1;
    while ((prod - cons) >= 7) @(negedge clk);
    sd   = SRC_RING + (prod % 8) * 16;
    dd   = DST_RING + (prod % 8) * 16;
    srca = 'h0010_0000 + k * 'h1_0000;
    dsta = 'h0080_0000 + k * 'h1_0000;
    k++;
    sw1 = (32'(last) << 30) | (32'(len) << 16) | 32'h0000_3C21;
    dw1 = (32'(len) << 16) | 32'h0000_00A5;
    mem[sd] = srca; mem[sd+4] = sw1; mem[dd] = dsta; mem[dd+4] = dw1;
    le    = (len > 'h3F80) ? 'h3F80 : len;  // R4 clamp
    words = (le + 3) / 4;
    bw    = (bsel == 2'd0) ? 1 : (bsel == 2'd1) ? 4 : 16;
    exp_q.push_back('{0, sd, 0, "R2 fetch src w0"});
    exp_q.push_back('{0, sd + 4, 0, "R2 fetch src w1"});
    exp_q.push_back('{0, dd, 0, "R2 fetch dst w0"});
    exp_q.push_back('{0, dd + 4, 0, "R2 fetch dst w1"});
    rem = words; off = 0;
    while (rem > 0) begin
      b = (rem < bw) ? rem : bw;
      for (int i = 0; i < b; i++) exp_q.push_back('{0, srca + 4 * (off + i), 0, "R5 burst read"});
      for (int i = 0; i < b; i++)
        exp_q.push_back('{1, dsta + 4 * (off + i), rd_word(srca + 4 * (off + i)), "R3 data write"});
      off += b; rem -= b;
    end
    if (wb_en) exp_q.push_back('{1, dd + 4, dw1 | 32'h8000_0000, "R6 done write-back"});
    cnt_q.push_back(4 + 2 * words + (wb_en ? 1 : 0));
    seg_q.push_back(last);
    @(negedge clk);
    prod++;
  endtask

  task automatic drain();
    while (prod != cons || busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] s, input logic w, input bit st);
    drain();
    bsel = s; wb_en = w; stall_en = st;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(adv == 1'b0 && seg_last == 1'b0, "R1 advance", adv, 0);
    check(req == 1'b0, "R1 request", req, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 1'b0 && req == 1'b0, "R1 idle after reset", busy, 0);

    set_cfg(2'd2, 1'b1, 1'b0);
    push_desc(40, 1'b1);        // R3 single short burst
    push_desc(6, 1'b0);         // R3 non-multiple-of-4 length
    set_cfg(2'd1, 1'b1, 1'b1);
    push_desc(40, 1'b0);        // R5 runs of 4,4,2 with stalls (R10)
    push_desc(64, 1'b1);
    push_desc(4, 1'b0);
    set_cfg(2'd0, 1'b1, 1'b1);
    push_desc(12, 1'b1);        // R5 single-word bursts
    set_cfg(2'd3, 1'b1, 1'b1);
    push_desc(0, 1'b1);         // R7 zero length with write-back
    push_desc(68, 1'b0);        // R5 16+1 split
    set_cfg(2'd2, 1'b0, 1'b0);
    push_desc(0, 1'b0);         // R7 zero length, no write-back
    push_desc(8, 1'b1);         // R6 write-back disabled
    set_cfg(2'd2, 1'b1, 1'b0);
    push_desc('h3FFF, 1'b1);    // R4 clamp to 4064 words
    drain();
    check(exp_q.size() == 0, "R3 all expected accesses seen", exp_q.size(), 0);
    check(busy == 1'b0 && adv == 1'b0, "R9 idle at end", busy, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", prod - cons, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule